// File: doc/BRIEF.md
# Two-Phase Halfband Decimator (7 taps, factor 2)

This block filters a stream of 16-bit signed samples with a 7-tap halfband FIR and keeps every second result. Only the kept outputs are computed: samples are sorted into an even-indexed stream and an odd-indexed stream, and each stream feeds its own sub-filter at half the input rate. Even samples only ever meet the even coefficients C0, C2, C4 and C6. Odd samples only ever meet C3, the single non-zero odd tap of a halfband response. So the odd sub-filter is just a short delay line and one multiplier.

The two sub-filter results are registered and added. The sum is rounded to a width chosen per output and clamped, then presented on a 16-bit port with a one-cycle valid strobe. A mode pin picks the input form. In interleaved mode one sample arrives per accepted cycle and the block tracks the parity itself. In paired mode an even sample and the following odd sample arrive together on two ports. Coefficients are loaded through a small write port.

Top module: `hb_decim2`

## Requirements
- R1: Kept output k equals the sum over i = 0..6 of X(2k+i)·C(i), where X(n) is the n-th accepted sample after reset. Samples and coefficients are Q1.15. The full-precision sum is Q2.30 and is held in a 35-bit accumulator that never overflows.
- R2: Interleaved mode (`ext_mode`=0). Each cycle with `in_valid`=1 accepts one sample on `din`. The first accepted sample after reset has index 0 (even) and parity then alternates. An accepted even sample with index n ≥ 6 produces output k = (n−6)/2. `dout_valid` is high for one cycle, two clock edges after the accepting edge.
- R3: Paired mode (`ext_mode`=1). Each cycle with `in_valid`=1 accepts X(2j) on `din` and X(2j+1) on `din_odd`. Pair j ≥ 3 produces output k = j−3, two clock edges after the accepting edge.
- R4: A write with `coef_we`=1 at address a ∈ {0,2,3,4,6} loads C(a) from `coef_wdata`. Writes to addresses 1, 5 and 7 change nothing. C1 and C5 are always zero.
- R5: The 16-bit result is the Q2.30 sum scaled to Q1.15, i.e. divided by 2^15.
- R6: `rnd_sel` sets the number of kept bits: 000→8, 001→9, 010→10, 011→11, 100→12, 101→14. With D dropped bits, the block adds 2^(14+D) to the sum, shifts it right arithmetically by 15+D and clamps to a signed (16−D)-bit range. It then shifts left by D, so the D low bits of `dout` are zero (round half up).
- R7: `rnd_sel`=110 keeps all 16 bits: the sum is rounded half up by 2^15, then clamped.
- R8: `rnd_sel`=111 forces `dout` to zero. `dout_valid` still pulses as usual.
- R9: A result beyond the kept range saturates to the largest or smallest value of that range.
- R10: Synchronous active-low reset clears the delay lines, the parity toggle, the coefficients and the output registers. After reset `dout`=0 and `dout_valid`=0, and no output appears until the required samples have arrived again.
- R11: Cycles with `in_valid`=0 accept nothing, whatever `din` and `din_odd` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ext_mode | input | 1 | 0 interleaved input, 1 paired input; held constant between resets |
| rnd_sel | input | 3 | Output precision code |
| in_valid | input | 1 | Accept input this cycle |
| din | input | 16 | Sample (interleaved) or even sample (paired) |
| din_odd | input | 16 | Odd sample in paired mode |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 3 | Coefficient index 0..6 |
| coef_wdata | input | 16 | Coefficient value, Q1.15 |
| dout | output | 16 | Rounded filtered output |
| dout_valid | output | 1 | One-cycle strobe per kept output |

## Verification
If the parity toggle is wrong, every output mixes even and odd samples with the wrong coefficients. Values then differ from the first kept output on, and in interleaved mode the strobes land one input late. A stale or shifted delay-line entry corrupts the first output that uses it, within four even samples. A fault in the odd branch shows only when C3 is non-zero, so coefficient sets with a large centre tap are used. A slip in the round or clamp path shows in the low bits or at the rails on the next output.

// File: rtl/hb_pkg.sv
// Shared constants and helpers for the halfband decimator.
// Assumes 16-bit Q1.15 samples and coefficients.
package hb_pkg;
    localparam int unsigned HB_DW   = 16;
    localparam int unsigned HB_CW   = 16;
    localparam int unsigned HB_AW   = 35;
    localparam int unsigned HB_FRAC = 15;
    localparam int unsigned HB_NTAP = 7;

    // Number of low output bits cleared for each precision code.
    function automatic int unsigned drop_of(input logic [2:0] code);
        case (code)
            3'b000:  drop_of = 8;
            3'b001:  drop_of = 7;
            3'b010:  drop_of = 6;
            3'b011:  drop_of = 5;
            3'b100:  drop_of = 4;
            3'b101:  drop_of = 2;
            default: drop_of = 0;
        endcase
    endfunction
endpackage

// File: rtl/hb_splitter.sv
// Sorts accepted input into even and odd sample strobes.
// Interleaved mode tracks parity with a toggle that starts even after reset.
// Paired mode raises both strobes together. ext_mode is assumed static between resets.
module hb_splitter #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_mode,
    input  logic          in_valid,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] din_odd,
    output logic          even_stb,
    output logic [DW-1:0] even_data,
    output logic          odd_stb,
    output logic [DW-1:0] odd_data
);
    logic odd_phase;

    // Parity toggle: flips on each accepted sample in interleaved mode.
    always_ff @(posedge clk) begin
        if (!rst_n)         odd_phase <= 1'b0;
        else if (ext_mode)  odd_phase <= 1'b0;
        else if (in_valid)  odd_phase <= ~odd_phase;
    end

    // Routing of data and strobes for both input forms.
    always_comb begin
        if (ext_mode) begin
            even_stb  = in_valid;
            odd_stb   = in_valid;
            even_data = din;
            odd_data  = din_odd;
        end else begin
            even_stb  = in_valid && !odd_phase;
            odd_stb   = in_valid &&  odd_phase;
            even_data = din;
            odd_data  = din;
        end
    end

    // R2: an even sample in interleaved mode is never followed directly by another even one.
    a_r2_parity_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_mode && even_stb) |=> (ext_mode || !even_stb));

    // R3: paired mode delivers both halves on the same cycle.
    a_r3_pair_together: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && in_valid) |-> (even_stb && odd_stb));
endmodule

// File: rtl/hb_coef_bank.sv
// Coefficient store. It keeps only the taps a halfband filter needs:
// the even taps plus the centre. Writes to the other odd taps and to
// out-of-range addresses are dropped. Assumes NTAP = 4n+3.
module hb_coef_bank #(
    parameter int unsigned CW   = 16,
    parameter int unsigned NTAP = 7,
    parameter int unsigned AB   = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [AB-1:0]                    addr,
    input  logic [CW-1:0]                    wdata,
    output logic [((NTAP+1)/2)*CW-1:0]       c_even,
    output logic [CW-1:0]                    c_ctr
);
    localparam int unsigned NE  = (NTAP + 1) / 2;
    localparam int unsigned CTR = NTAP / 2;

    logic addr_ok;
    assign addr_ok = (32'(addr) < NTAP);

    for (genvar m = 0; m < NE; m++) begin : g_even
        logic [CW-1:0] c_q;
        // Even coefficient register m holds C(2m).
        always_ff @(posedge clk) begin
            if (!rst_n) c_q <= '0;
            else if (we && addr_ok && (32'(addr) == 2*m)) c_q <= wdata;
        end
        assign c_even[m*CW +: CW] = c_q;
    end

    // Centre-tap register.
    always_ff @(posedge clk) begin
        if (!rst_n) c_ctr <= '0;
        else if (we && (32'(addr) == CTR)) c_ctr <= wdata;
    end

    // R4: a write to a zero tap or past the end leaves every coefficient unchanged.
    a_r4_hole_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr[0] == 1'b1) && (32'(addr) != CTR)) |=> ($stable(c_even) && $stable(c_ctr)));
endmodule

// File: rtl/hb_even_branch.sv
// Even sub-filter. It keeps the last NE-1 even samples and, on each new
// even sample, forms the NE-term product sum with C0, C2, ... .
// The sum is registered and flagged valid once the line has filled.
module hb_even_branch #(
    parameter int unsigned DW = 16,
    parameter int unsigned CW = 16,
    parameter int unsigned AW = 35,
    parameter int unsigned NE = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stb,
    input  logic [DW-1:0]        x,
    input  logic [NE*CW-1:0]     c_even,
    output logic signed [AW-1:0] sum_q,
    output logic                 vld_q
);
    localparam int unsigned PW = DW + CW;
    localparam int unsigned FW = $clog2(NE);

    logic [DW-1:0]        line_q [NE-1];
    logic [FW-1:0]        fill_q;
    logic signed [AW-1:0] term [NE];
    logic signed [AW-1:0] sum_c;

    for (genvar m = 0; m < NE; m++) begin : g_tap
        logic signed [DW-1:0] s;
        logic signed [CW-1:0] c;
        logic signed [PW-1:0] p;
        // Tap m multiplies X(2k+2m); the newest sample belongs to the last tap.
        if (m == NE - 1) begin : g_new
            assign s = x;
        end else begin : g_old
            assign s = line_q[NE-2-m];
        end
        assign c       = c_even[m*CW +: CW];
        assign p       = s * c;
        assign term[m] = {{(AW-PW){p[PW-1]}}, p};
    end

    // Adder tree over the even taps.
    always_comb begin
        sum_c = '0;
        for (int m = 0; m < NE; m++) sum_c = sum_c + term[m];
    end

    // Delay line shift on each even sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NE - 1; i++) line_q[i] <= '0;
        end else if (stb) begin
            line_q[0] <= x;
            for (int i = 1; i < NE - 1; i++) line_q[i] <= line_q[i-1];
        end
    end

    // Fill counter: counts even samples until the line is full.
    always_ff @(posedge clk) begin
        if (!rst_n) fill_q <= '0;
        else if (stb && (32'(fill_q) < NE - 1)) fill_q <= fill_q + 1'b1;
    end

    // Result register for the even sub-filter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= stb && (32'(fill_q) == NE - 1);
            if (stb) sum_q <= sum_c;
        end
    end

    // R2: a sub-filter result is only ever flagged right after an even sample.
    a_r2_vld_after_even: assert property (@(posedge clk) disable iff (!rst_n)
        vld_q |-> $past(stb));

    // R10: the very first even sample after reset never yields a result.
    a_r10_no_early_result: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && fill_q == '0) |=> !vld_q);
endmodule

// File: rtl/hb_odd_branch.sv
// Odd sub-filter of a halfband filter. It is a delay line of odd samples
// and a single multiply by the centre coefficient, with no accumulation.
// The product is registered when an even sample arrives.
module hb_odd_branch #(
    parameter int unsigned DW    = 16,
    parameter int unsigned CW    = 16,
    parameter int unsigned AW    = 35,
    parameter int unsigned DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 odd_stb,
    input  logic [DW-1:0]        x,
    input  logic                 even_stb,
    input  logic [CW-1:0]        c_ctr,
    output logic signed [AW-1:0] prod_q
);
    localparam int unsigned PW = DW + CW;

    logic [DW-1:0]        line_q [DEPTH];
    logic signed [PW-1:0] p;

    assign p = $signed(line_q[DEPTH-1]) * $signed(c_ctr);

    // Odd-sample delay line, shifted on each odd sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
        end else if (odd_stb) begin
            line_q[0] <= x;
            for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
        end
    end

    // Centre-tap product register, aligned with the even branch result.
    always_ff @(posedge clk) begin
        if (!rst_n)        prod_q <= '0;
        else if (even_stb) prod_q <= {{(AW-PW){p[PW-1]}}, p};
    end

    // R1: the centre product only changes when an even sample closes an output.
    a_r1_ctr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(even_stb) |-> $stable(prod_q));
endmodule

// File: rtl/hb_out_stage.sv
// Adds the two sub-filter results, rounds half up at the selected
// precision, clamps to that range and registers the output with its strobe.
module hb_out_stage #(
    parameter int unsigned DW   = 16,
    parameter int unsigned AW   = 35,
    parameter int unsigned FRAC = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [AW-1:0] sum_e,
    input  logic signed [AW-1:0] sum_o,
    input  logic [2:0]           rnd,
    output logic [DW-1:0]        dout,
    output logic                 dout_valid
);
    import hb_pkg::*;
    localparam int unsigned WW = AW + 1;

    logic signed [WW-1:0] total, biased, q, hi, lo, clamped, one;
    logic signed [WW-1:0] shifted;
    logic [DW-1:0]        res;
    int unsigned          drop, sh;

    // Rounding and saturation at the precision chosen by rnd.
    always_comb begin
        one     = 1;
        drop    = drop_of(rnd);
        sh      = FRAC + drop;
        total   = {sum_e[AW-1], sum_e} + {sum_o[AW-1], sum_o};
        biased  = total + (one <<< (sh - 1));
        q       = biased >>> sh;
        hi      = (one <<< (DW - 1 - drop)) - one;
        lo      = -hi - one;
        if (q > hi)      clamped = hi;
        else if (q < lo) clamped = lo;
        else             clamped = q;
        shifted = clamped <<< drop;
        res     = shifted[DW-1:0];
        if (rnd == 3'b111) res = '0;
    end

    // Output register and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            dout_valid <= in_vld;
            if (in_vld) dout <= res;
        end
    end

    // R8: code 111 yields zero on every strobe.
    a_r8_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && $past(rnd) == 3'b111) |-> (dout == '0));

    // R6: at 8 kept bits the low byte is clear.
    a_r6_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_valid && $past(rnd) == 3'b000) |-> (dout[7:0] == 8'h00));

    // R2: every strobe is preceded by a sub-filter result.
    a_r2_strobe_follows_result: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> $past(in_vld));
endmodule

// File: rtl/hb_decim2.sv
// Top of the halfband decimate-by-two filter. It wires the splitter,
// coefficient store, both sub-filters and the output stage together.
// Latency is two edges from the accepting edge to dout_valid.
module hb_decim2 #(
    parameter int unsigned DW   = hb_pkg::HB_DW,
    parameter int unsigned CW   = hb_pkg::HB_CW,
    parameter int unsigned AW   = hb_pkg::HB_AW,
    parameter int unsigned FRAC = hb_pkg::HB_FRAC,
    parameter int unsigned NTAP = hb_pkg::HB_NTAP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_mode,
    input  logic [2:0]    rnd_sel,
    input  logic          in_valid,
    input  logic [DW-1:0] din,
    input  logic [DW-1:0] din_odd,
    input  logic          coef_we,
    input  logic [2:0]    coef_addr,
    input  logic [CW-1:0] coef_wdata,
    output logic [DW-1:0] dout,
    output logic          dout_valid
);
    localparam int unsigned NE   = (NTAP + 1) / 2;
    localparam int unsigned CTR  = NTAP / 2;
    localparam int unsigned ODEP = (CTR + 1) / 2;

    logic                 even_stb, odd_stb;
    logic [DW-1:0]        even_data, odd_data;
    logic [NE*CW-1:0]     c_even;
    logic [CW-1:0]        c_ctr;
    logic signed [AW-1:0] sum_e, prod_o;
    logic                 vld_e;

    hb_splitter #(.DW(DW)) u_split (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .in_valid(in_valid),
        .din(din), .din_odd(din_odd),
        .even_stb(even_stb), .even_data(even_data),
        .odd_stb(odd_stb), .odd_data(odd_data)
    );

    hb_coef_bank #(.CW(CW), .NTAP(NTAP), .AB(3)) u_coef (
        .clk(clk), .rst_n(rst_n), .we(coef_we), .addr(coef_addr),
        .wdata(coef_wdata), .c_even(c_even), .c_ctr(c_ctr)
    );

    hb_even_branch #(.DW(DW), .CW(CW), .AW(AW), .NE(NE)) u_even (
        .clk(clk), .rst_n(rst_n), .stb(even_stb), .x(even_data),
        .c_even(c_even), .sum_q(sum_e), .vld_q(vld_e)
    );

    hb_odd_branch #(.DW(DW), .CW(CW), .AW(AW), .DEPTH(ODEP)) u_odd (
        .clk(clk), .rst_n(rst_n), .odd_stb(odd_stb), .x(odd_data),
        .even_stb(even_stb), .c_ctr(c_ctr), .prod_q(prod_o)
    );

    hb_out_stage #(.DW(DW), .AW(AW), .FRAC(FRAC)) u_out (
        .clk(clk), .rst_n(rst_n), .in_vld(vld_e), .sum_e(sum_e), .sum_o(prod_o),
        .rnd(rnd_sel), .dout(dout), .dout_valid(dout_valid)
    );

    // R10: nothing comes out in the cycle right after reset is released.
    a_r10_quiet_after_reset: assert property (@(posedge clk)
        (!$past(rst_n) && rst_n) |-> !dout_valid);
endmodule

// File: tb/hb_decim2_tb.sv
module hb_decim2_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_mode = 1'b0;
    logic [2:0]  rnd_sel = 3'b110;
    logic        in_valid = 1'b0;
    logic [15:0] din = '0, din_odd = '0;
    logic        coef_we = 1'b0;
    logic [2:0]  coef_addr = '0;
    logic [15:0] coef_wdata = '0;
    logic [15:0] dout;
    logic        dout_valid;

    int checks = 0, fails = 0;
    int cyc = 0;
    longint xs [0:1023];
    longint mc [0:6];
    int n = 0;
    int exp_cyc [$];
    logic [15:0] exp_val [$];
    string exp_tag [$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hb_decim2 u_dut (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .rnd_sel(rnd_sel),
        .in_valid(in_valid), .din(din), .din_odd(din_odd),
        .coef_we(coef_we), .coef_addr(coef_addr), .coef_wdata(coef_wdata),
        .dout(dout), .dout_valid(dout_valid)
    );

    function automatic logic [15:0] model_round(longint acc, logic [2:0] code);
        int d;
        longint q, hi, lo;
        case (code)
            3'd0: d = 8; 3'd1: d = 7; 3'd2: d = 6; 3'd3: d = 5;
            3'd4: d = 4; 3'd5: d = 2; 3'd6: d = 0;
            default: return 16'h0000;
        endcase
        q  = (acc + (longint'(1) <<< (14 + d))) >>> (15 + d);
        hi = (longint'(1) <<< (15 - d)) - 1;
        lo = -hi - 1;
        if (q > hi) q = hi;
        if (q < lo) q = lo;
        return 16'(q <<< d);
    endfunction

    function automatic logic [15:0] model_out(int k);
        longint acc = 0;
        for (int i = 0; i < 7; i++) acc += xs[2*k+i] * mc[i];
        return model_round(acc, rnd_sel);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Output monitor: every strobe must match the next expected value and cycle.
    always @(negedge clk) begin
        if (rst_n && dout_valid) begin
            if (exp_val.size() == 0) begin
                checks++; fails++;
                $display("FAIL R11 spurious strobe actual=%h expected=none", dout);
            end else begin
                check({exp_tag[0], " strobe cycle"}, cyc, exp_cyc[0]);
                check({exp_tag[0], " value"}, dout, exp_val[0]);
                void'(exp_cyc.pop_front()); void'(exp_val.pop_front()); void'(exp_tag.pop_front());
            end
        end
    end

    task automatic do_reset(logic mode);
        @(negedge clk);
        rst_n = 1'b0; ext_mode = mode; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n = 0;
        for (int i = 0; i < 7; i++) mc[i] = 0;
        // R10: outputs cleared by reset
        check("R10 reset dout", dout, 16'h0000);
        check("R10 reset valid", dout_valid, 1'b0);
    endtask

    task automatic wcoef(int a, longint v);
        coef_we = 1'b1; coef_addr = 3'(a); coef_wdata = 16'(v);
        @(negedge clk);
        coef_we = 1'b0;
        if (a == 0 || a == 2 || a == 3 || a == 4 || a == 6) mc[a] = longint'($signed(16'(v)));
    endtask

    task automatic idle(int m);
        for (int i = 0; i < m; i++) begin
            din = 16'($urandom); din_odd = 16'($urandom);
            @(negedge clk);
        end
    endtask

    task automatic send_int(logic [15:0] x, string tag);
        din = x; in_valid = 1'b1;
        xs[n] = longint'($signed(x));
        if (n % 2 == 0 && n >= 6) begin
            exp_cyc.push_back(cyc + 2); exp_val.push_back(model_out((n - 6) / 2)); exp_tag.push_back(tag);
        end
        n++;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_ext(logic [15:0] xe, logic [15:0] xo, string tag);
        din = xe; din_odd = xo; in_valid = 1'b1;
        xs[n] = longint'($signed(xe)); xs[n+1] = longint'($signed(xo));
        if (n / 2 >= 3) begin
            exp_cyc.push_back(cyc + 2); exp_val.push_back(model_out(n / 2 - 3)); exp_tag.push_back(tag);
        end
        n += 2;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain(string tag);
        idle(4);
        check({tag, " missing outputs"}, exp_val.size(), 0);
        exp_val.delete(); exp_cyc.delete(); exp_tag.delete();
    endtask

    task automatic load_random_coefs();
        for (int a = 0; a < 8; a++) wcoef(a, longint'($urandom_range(0, 65535)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset(1'b0);

        // R4: writes to 1,5,7 ignored; impulse response shows each stored tap
        wcoef(0, 100); wcoef(1, 16'h7000); wcoef(2, 200); wcoef(3, 16'h4000);
        wcoef(4, 300); wcoef(5, 16'h7000); wcoef(6, 400); wcoef(7, 16'h1234);
        rnd_sel = 3'b110;
        for (int i = 0; i < 16; i++) send_int((i == 7 || i == 8) ? 16'h7FFF : 16'h0000, "R4 impulse");
        drain("R4");

        // R1/R2/R5/R11: random interleaved stream with gaps, full precision
        do_reset(1'b0);
        load_random_coefs();
        for (int i = 0; i < 60; i++) begin
            send_int(16'($urandom), "R1 R2 interleaved");
            if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
        end
        drain("R2");

        // R7: round half up at full precision, C6 = 0.5
        do_reset(1'b0);
        wcoef(6, 16'h4000);
        rnd_sel = 3'b110;
        for (int i = 0; i < 12; i++) send_int((i % 4 == 2) ? 16'hFFFF : 16'h0001, "R7 half up");
        drain("R7");

        // R6/R8: every precision code on random data
        do_reset(1'b0);
        load_random_coefs();
        for (int code = 0; code < 8; code++) begin
            rnd_sel = 3'(code);
            for (int i = 0; i < 14; i++) send_int(16'($urandom), "R6 R8 precision");
            drain("R6");
        end

        // R9: saturation to both rails at several precisions
        do_reset(1'b0);
        for (int a = 0; a < 7; a++) wcoef(a, 16'h7FFF);
        for (int code = 0; code < 7; code += 3) begin
            rnd_sel = 3'(code);
            for (int i = 0; i < 10; i++) send_int(16'h7FFF, "R9 positive rail");
            for (int i = 0; i < 10; i++) send_int(16'h8000, "R9 negative rail");
            drain("R9");
        end

        // R3: paired mode with random data and gaps
        do_reset(1'b1);
        load_random_coefs();
        rnd_sel = 3'b110;
        for (int i = 0; i < 40; i++) begin
            send_ext(16'($urandom), 16'($urandom), "R3 paired");
            if ($urandom_range(0, 3) == 0) idle(2);
        end
        drain("R3");
        rnd_sel = 3'b001;
        for (int i = 0; i < 10; i++) send_ext(16'($urandom), 16'($urandom), "R3 R6 paired 9 bits");
        drain("R3b");

        // R10: reset mid-stream restarts parity and fill
        do_reset(1'b0);
        load_random_coefs();
        rnd_sel = 3'b110;
        for (int i = 0; i < 5; i++) send_int(16'($urandom), "R10 pre");
        drain("R10 pre");
        do_reset(1'b0);
        load_random_coefs();
        for (int i = 0; i < 20; i++) send_int(16'($urandom), "R10 restart");
        drain("R10");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule